// File: doc/BRIEF.md
# Reset Sequencer and Boot Mode Selector

This block produces the single internal reset of a small controller. It merges three causes: the supply coming up (a power-good input that is low while the supply is absent), a low level on the shared open-drain reset pin, and expiry of a built-in watchdog. After power-good rises, reset is held for a fixed count of clock cycles. On a watchdog expiry the block pulls the shared pin low for a few cycles, so that other devices on the board reset too. It then waits for the pin to read high again before it releases the internal reset.

On the clock edge that ends a reset, two mode straps are captured. They choose bootstrap, single-chip, test or expanded operation, and the block outputs the address where the processor fetches its start vector. The watchdog counts only while the system is out of reset and enabled. Software restarts it by writing an unlock byte and then a confirm byte. A cause code shows which source started the most recent reset.

All control and status pins are plain levels. The service write is a single-cycle strobe with no back-pressure: every cycle with `svc_wr` high is one accepted byte.

Top module: `rstmc_ctrl`

## Requirements
- R1: After `pwr_good` rises, `sys_rst` stays high for exactly POR_CYCLES (default 4064) rising clock edges and is low after the POR_CYCLES-th edge.
- R2: While `pwr_good` is low, `sys_rst` is high at once, without waiting for a clock, and `cause` reads 2'b01 (power-on).
- R3: A low on `rst_pin_in` passes a two-flop synchronizer. It raises `sys_rst` after the third rising edge and sets `cause` to 2'b10 (external). `sys_rst` falls on the third edge after the pin returns high, and the block never pulls the pin for this cause.
- R4: On a watchdog expiry `rst_pin_pull` is high for exactly PIN_CYCLES (default 4) consecutive cycles, only while `sys_rst` is high. `sys_rst` is released once the synchronized pin reads high again.
- R5: With the watchdog enabled and no restart, `sys_rst` rises on the WDOG_CYCLES-th (default 1000) rising edge after release, with `cause` set to 2'b11 (watchdog).
- R6: A restart is a write of 8'h55 and then, as the next write, 8'hAA. Idle cycles between the two are allowed. A restart on edge r moves the expiry to edge r+WDOG_CYCLES. Any other write sequence leaves the count running.
- R7: While `wdog_off` is high the watchdog never expires.
- R8: `mode` equals {`mode_a`,`mode_b`} as sampled on the edge where `sys_rst` falls, and holds that value until the next reset. The codes are 00 bootstrap, 01 single-chip, 10 test and 11 expanded.
- R9: `vec_addr` is 16'hFFFE when `mode[0]` is 1 (single-chip or expanded) and 16'hBFFE when `mode[0]` is 0 (bootstrap or test).
- R10: `cause` keeps its value until the next reset starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good | input | 1 | Supply present; low acts as the power-on reset, asynchronously |
| rst_pin_in | input | 1 | Level read back from the shared reset pin, active low |
| rst_pin_pull | output | 1 | Enable of the open-drain pull-down on the reset pin |
| mode_a | input | 1 | First mode strap |
| mode_b | input | 1 | Second mode strap |
| wdog_off | input | 1 | Non-volatile watchdog disable |
| svc_wr | input | 1 | Watchdog service write strobe |
| svc_data | input | 8 | Watchdog service byte |
| sys_rst | output | 1 | Internal reset, active high |
| mode | output | 2 | Captured operating mode |
| vec_addr | output | 16 | Address of the reset vector |
| cause | output | 2 | Source of the last reset |

## Verification
The hardest state to reach is a watchdog expiry whose timing depends on a long mix of service writes. In that mix, unlock and confirm bytes can be interleaved with stray bytes and idle cycles, and only an exact unlock-then-confirm pair moves the deadline. The bench drives thousands of cycles of random writes that are heavy in 8'h55 and 8'hAA. A small model of the arming rule computes the edge on which reset must rise, and the bench compares it with the edge on which it actually rises. Expiry also sets off the pin pulse and the read-back wait, which the bench closes through its own wired-AND model of the pin.

// File: rtl/rstmc_pkg.sv
package rstmc_pkg;
  typedef enum logic [2:0] {
    ST_POR, ST_RUN, ST_EXT, ST_DRIVE, ST_WAIT
  } seq_state_t;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_POR  = 2'b01,
    CAUSE_EXT  = 2'b10,
    CAUSE_WDOG = 2'b11
  } cause_t;

  localparam logic [7:0] SVC_UNLOCK  = 8'h55;
  localparam logic [7:0] SVC_CONFIRM = 8'hAA;

  localparam logic [15:0] VEC_NORMAL  = 16'hFFFE;
  localparam logic [15:0] VEC_SPECIAL = 16'hBFFE;

  function automatic logic [15:0] vector_of(input logic [1:0] m);
    return m[0] ? VEC_NORMAL : VEC_SPECIAL;
  endfunction
endpackage

// File: rtl/rstmc_sync.sv
module rstmc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= d;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rstmc_wdog.sv
module rstmc_wdog
  import rstmc_pkg::*;
#(
  parameter int LIMIT = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       enable,
  input  logic       svc_wr,
  input  logic [7:0] svc_data,
  output logic       timeout
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;
  logic         armed;
  logic         restart;

  assign restart = svc_wr && (svc_data == SVC_CONFIRM) && armed;
  assign timeout = run && enable && !restart && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else begin
      if (svc_wr) armed <= (svc_data == SVC_UNLOCK);
      if (restart || !enable) cnt <= '0;
      else if (cnt != LAST)   cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rstmc_seq.sv
module rstmc_seq
  import rstmc_pkg::*;
#(
  parameter int POR_CYCLES = 4064,
  parameter int PIN_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_high,
  input  logic       wdog_timeout,
  output seq_state_t state,
  output cause_t     cause,
  output logic       release_now
);
  localparam int MAXC = (POR_CYCLES > PIN_CYCLES) ? POR_CYCLES : PIN_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] POR_LAST = CW'(POR_CYCLES - 1);
  localparam logic [CW-1:0] PIN_LAST = CW'(PIN_CYCLES - 1);

  seq_state_t    nxt;
  logic [CW-1:0] cnt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_POR:   if (cnt == POR_LAST) nxt = ST_RUN;
      ST_RUN:   if (wdog_timeout)    nxt = ST_DRIVE;
                else if (!pin_high)  nxt = ST_EXT;
      ST_EXT:   if (pin_high)        nxt = ST_RUN;
      ST_DRIVE: if (cnt == PIN_LAST) nxt = ST_WAIT;
      ST_WAIT:  if (pin_high)        nxt = ST_RUN;
      default:                       nxt = ST_POR;
    endcase
  end

  assign release_now = (state != ST_RUN) && (nxt == ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_POR;
      cnt   <= '0;
      cause <= CAUSE_POR;
    end else begin
      state <= nxt;
      if (nxt != state) cnt <= '0;
      else              cnt <= cnt + 1'b1;
      if (state == ST_RUN && nxt == ST_DRIVE) cause <= CAUSE_WDOG;
      if (state == ST_RUN && nxt == ST_EXT)   cause <= CAUSE_EXT;
    end
  end
endmodule

// File: rtl/rstmc_mode.sv
module rstmc_mode
  import rstmc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        capture,
  input  logic        strap_a,
  input  logic        strap_b,
  output logic [1:0]  mode,
  output logic [15:0] vec_addr
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mode <= 2'b00;
    else if (capture) mode <= {strap_a, strap_b};

  assign vec_addr = vector_of(mode);
endmodule

// File: rtl/rstmc_ctrl.sv
module rstmc_ctrl
  import rstmc_pkg::*;
#(
  parameter int POR_CYCLES  = 4064,
  parameter int PIN_CYCLES  = 4,
  parameter int WDOG_CYCLES = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        pwr_good,
  input  logic        rst_pin_in,
  output logic        rst_pin_pull,
  input  logic        mode_a,
  input  logic        mode_b,
  input  logic        wdog_off,
  input  logic        svc_wr,
  input  logic [7:0]  svc_data,
  output logic        sys_rst,
  output logic [1:0]  mode,
  output logic [15:0] vec_addr,
  output logic [1:0]  cause
);
  seq_state_t state;
  cause_t     cause_q;
  logic       pin_high;
  logic       timeout;
  logic       release_now;

  rstmc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(pwr_good), .d(rst_pin_in), .q(pin_high)
  );

  rstmc_wdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
    .clk(clk), .rst_n(pwr_good), .run(state == ST_RUN), .enable(!wdog_off),
    .svc_wr(svc_wr), .svc_data(svc_data), .timeout(timeout)
  );

  rstmc_seq #(.POR_CYCLES(POR_CYCLES), .PIN_CYCLES(PIN_CYCLES)) u_seq (
    .clk(clk), .rst_n(pwr_good), .pin_high(pin_high), .wdog_timeout(timeout),
    .state(state), .cause(cause_q), .release_now(release_now)
  );

  rstmc_mode u_mode (
    .clk(clk), .rst_n(pwr_good), .capture(release_now),
    .strap_a(mode_a), .strap_b(mode_b), .mode(mode), .vec_addr(vec_addr)
  );

  assign sys_rst      = !pwr_good || (state != ST_RUN);
  assign rst_pin_pull = pwr_good && (state == ST_DRIVE);
  assign cause        = cause_q;
endmodule

// File: rtl/rstmc_ctrl_chk.sv
module rstmc_ctrl_chk #(
  parameter int PIN_CYCLES = 4
) (
  input logic        clk,
  input logic        pwr_good,
  input logic        rst_pin_pull,
  input logic        sys_rst,
  input logic [1:0]  mode,
  input logic [15:0] vec_addr,
  input logic [1:0]  cause
);
  localparam int DW = $clog2(PIN_CYCLES + 2);
  logic [DW-1:0] drv_cnt;

  always_ff @(posedge clk or negedge pwr_good)
    if (!pwr_good)         drv_cnt <= '0;
    else if (rst_pin_pull) drv_cnt <= drv_cnt + 1'b1;
    else                   drv_cnt <= '0;

  AST_PULL_IN_RESET: assert property (@(posedge clk) disable iff (!pwr_good)
    rst_pin_pull |-> sys_rst); // R4
  AST_PULL_BOUNDED: assert property (@(posedge clk) disable iff (!pwr_good)
    rst_pin_pull |-> (drv_cnt < DW'(PIN_CYCLES))); // R4
  AST_PULL_EXACT: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(rst_pin_pull) |-> (drv_cnt == DW'(PIN_CYCLES))); // R4
  AST_PULL_CAUSE: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(rst_pin_pull) |-> (cause == 2'b11)); // R5
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!pwr_good)
    (!sys_rst && $past(!sys_rst)) |-> $stable(mode)); // R8
  AST_VEC_SPECIAL: assert property (@(posedge clk) disable iff (!pwr_good)
    !mode[0] |-> (vec_addr == 16'hBFFE)); // R9
  AST_CAUSE_HELD: assert property (@(posedge clk) disable iff (!pwr_good)
    (!sys_rst && $past(!sys_rst)) |-> $stable(cause)); // R10
endmodule

bind rstmc_ctrl rstmc_ctrl_chk #(.PIN_CYCLES(PIN_CYCLES)) u_chk (
  .clk(clk), .pwr_good(pwr_good), .rst_pin_pull(rst_pin_pull),
  .sys_rst(sys_rst), .mode(mode), .vec_addr(vec_addr), .cause(cause)
);

// File: tb/rstmc_ctrl_test.sv
`timescale 1ns/1ps
module rstmc_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int POR_N  = 4064;
  localparam int PIN_N  = 4;
  localparam int WDOG_N = 1000;

  logic clk = 1'b0;
  logic pwr_good = 1'b0, ext_low = 1'b0, mode_a = 1'b1, mode_b = 1'b1;
  logic wdog_off = 1'b0, svc_wr = 1'b0;
  logic [7:0] svc_data = 8'h00;
  logic rst_pin_pull, sys_rst;
  logic [1:0] mode, cause;
  logic [15:0] vec_addr;
  logic rst_pin_in;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rst_pin_in = !(ext_low || rst_pin_pull);

  rstmc_ctrl uut (
    .clk(clk), .pwr_good(pwr_good), .rst_pin_in(rst_pin_in),
    .rst_pin_pull(rst_pin_pull), .mode_a(mode_a), .mode_b(mode_b),
    .wdog_off(wdog_off), .svc_wr(svc_wr), .svc_data(svc_data),
    .sys_rst(sys_rst), .mode(mode), .vec_addr(vec_addr), .cause(cause)
  );

  function automatic logic [15:0] exp_vec(input logic [1:0] m);
    return m[0] ? 16'hFFFE : 16'hBFFE;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Called at the negedge right after the release edge (edge 0).
  task automatic run_wdog(input bit allow_svc);
    int r = 0;
    bit armed = 0;
    int hit = -1;
    for (int k = 1; k < 4000; k++) begin
      logic wr;
      logic [7:0] d;
      int pick;
      wr = 1'($urandom);
      pick = int'($urandom % 3);
      d = 8'($urandom);
      if (allow_svc && k < 2000) begin
        if (pick == 0) d = 8'h55;
        else if (pick == 1) d = 8'hAA;
      end else if (d == 8'hAA || d == 8'h55) d = 8'h3C;
      svc_wr = wr;
      svc_data = d;
      if (wr && d == 8'hAA && armed) r = k;
      if (wr) armed = (d == 8'h55);
      step();
      if (sys_rst) begin
        hit = k;
        break;
      end
    end
    svc_wr = 1'b0;
    check(allow_svc ? "R6 expiry edge" : "R5 expiry edge", hit, r + WDOG_N);
    check("R5 cause", int'(cause), 3);
    begin
      int p = 0;
      while (rst_pin_pull && p < 20) begin
        p++;
        step();
      end
      check("R4 pull length", p, PIN_N);
    end
    begin
      int w = 0;
      while (sys_rst && w < 20) begin
        w++;
        step();
      end
      check("R4 released after pin high", int'(sys_rst), 0);
    end
  endtask

  initial begin : watchdog_timer
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog timer expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check("R2 reset while power low", int'(sys_rst), 1);
    check("R2 cause power-on", int'(cause), 1);
    check("R2 no pin pull", int'(rst_pin_pull), 0);

    pwr_good = 1'b1;
    begin
      int n = 0;
      while (sys_rst && n < 5000) begin
        n++;
        step();
      end
      check("R1 power-on hold", n, POR_N);
    end
    check("R8 mode after power-on", int'(mode), 3);
    check("R9 vector expanded", int'(vec_addr), int'(exp_vec(2'b11)));
    check("R10 cause kept", int'(cause), 1);

    run_wdog(0);
    run_wdog(1);
    run_wdog(1);
    run_wdog(1);

    wdog_off = 1'b1;
    for (int k = 0; k < 1500; k++) begin
      svc_wr = 1'($urandom);
      svc_data = 8'($urandom);
      step();
      if (sys_rst) break;
    end
    svc_wr = 1'b0;
    check("R7 disabled watchdog", int'(sys_rst), 0);

    for (int it = 0; it < 6; it++) begin
      logic [1:0] m;
      m = (it < 4) ? 2'(it) : 2'($urandom);
      ext_low = 1'b1;
      step();
      step();
      check("R3 not yet in reset", int'(sys_rst), 0);
      step();
      check("R3 external reset", int'(sys_rst), 1);
      check("R3 cause external", int'(cause), 2);
      check("R3 no pull", int'(rst_pin_pull), 0);
      {mode_a, mode_b} = m;
      repeat (5) step();
      ext_low = 1'b0;
      step();
      step();
      check("R3 still in reset", int'(sys_rst), 1);
      step();
      check("R3 released", int'(sys_rst), 0);
      check("R8 mode captured", int'(mode), int'(m));
      check("R9 vector", int'(vec_addr), int'(exp_vec(m)));
      {mode_a, mode_b} = ~m;
      repeat (3) step();
      check("R8 mode held", int'(mode), int'(m));
      check("R10 cause held", int'(cause), 2);
    end

    #(CLK_PERIOD/4);
    pwr_good = 1'b0;
    #1;
    check("R2 async reset", int'(sys_rst), 1);
    check("R2 cause power-on", int'(cause), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule